// File: doc/BRIEF.md
# Linked-List Command Block Walker

This block follows a chain of command blocks held in system RAM and feeds their payload words, one at a time, to a downstream command consumer. Every block begins with one header word. Its upper byte gives how many payload words follow the header, and its lower 24 bits give the address of the next block. After a `start` pulse the walker reads a header and then reads the payload words at the addresses that follow it. Each payload word goes out on a valid/ready port. The walker then moves to the linked block. It stops when the address it is about to visit has bit 23 set.

RAM is reached through a simple word-read port. A request is held until it is granted, and exactly one read data beat with `mem_rvalid` comes back one or more cycles after the grant. Only one read is outstanding at a time. While the walk runs, the block builds an estimate of its processing cost. If a chain never reaches the end marker, a node limit stops the walk and reports a likely loop. A `done` pulse marks the end of every walk. The cost total and the node count stay readable until the next start.

Top module: `cmdlist_walker`

## Requirements
- R1: A header word carries the payload length in bits 31:24 and the next block address in bits 23:0. The payload words are read from the word addresses directly after the header, in increasing order, and are emitted on `out_data` in that same order with none lost or repeated.
- R2: Before each block is visited, the pending address is tested. If its bit 23 is set, the walk ends. A `start_addr` that already has bit 23 set ends the walk with zero nodes, zero cost and no memory read.
- R3: RAM is addressed with bits 20:0 of the block address, forced to word alignment (`mem_addr[1:0]` = 0). Bits 22:21 are ignored, and payload addresses wrap within the 21-bit space. A request that has not been granted keeps `mem_req` high and keeps `mem_addr` unchanged.
- R4: `cost_total` adds 10 for every visited block, plus 5 + length when the length is not zero.
- R5: A block with length 0 is followed to its link with no payload read and no output word.
- R6: When MAX_NODES (8192) blocks have been visited and the next address still lacks bit 23, the walk stops with `err_loop` = 1 and `node_count` = MAX_NODES. No further read is issued.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. No payload read is issued while an output word is waiting.
- R8: `done` is a single-cycle pulse. It is raised after the walk ends and the last output word has been accepted. `busy` is high from the cycle after an accepted start until `done`. `cost_total`, `node_count` and `err_loop` keep their final values until the next start.
- R9: A `start` pulse while `busy` is high is ignored.
- R10: After reset the block is idle. `mem_req`, `out_valid`, `done`, `busy` and `err_loop` are 0, and the counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 24 | Address of the first block |
| mem_req | output | 1 | Read request |
| mem_addr | output | 21 | Byte address of the read, word aligned |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Downstream accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_loop | output | 1 | Walk was stopped by the node limit |
| cost_total | output | 32 | Accumulated cost estimate |
| node_count | output | 14 | Blocks visited in this walk |

## Verification
Two events can fall in the same clock cycle: the downstream port accepting a waiting payload word, and the fetch of the next block's header. The header read is allowed even while the output slot is full. The bench provokes this overlap by throttling `out_ready` to one cycle in four or every other cycle, and by stalling grants at the same time, on chains where a long block is followed by further blocks. A correct result is the exact expected word sequence with the expected number of grants, and with `out_data` never changing while it is stalled.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int CW_LEN_W  = 8;
  localparam int CW_LINK_W = 24;
  localparam int CW_WORD_W = CW_LEN_W + CW_LINK_W;
  localparam int CW_END_BIT = CW_LINK_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_HREQ,
    ST_HWAIT,
    ST_PREQ,
    ST_PWAIT,
    ST_DRAIN
  } cw_state_t;
endpackage

// File: rtl/cw_cost_acc.sv
module cw_cost_acc #(
  parameter int COST_W        = 32,
  parameter int LEN_W         = 8,
  parameter int NODE_COST     = 10,
  parameter int LEN_BASE_COST = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add_en,
  input  logic [LEN_W-1:0]  len,
  output logic [COST_W-1:0] cost
);
  logic [COST_W-1:0] len_part;

  always_comb begin
    if (len != '0) len_part = COST_W'(LEN_BASE_COST) + COST_W'(len);
    else           len_part = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  cost <= '0;
    else if (add_en) cost <= cost + COST_W'(NODE_COST) + len_part;
  end
endmodule

// File: rtl/cw_node_guard.sv
module cw_node_guard #(
  parameter int MAX_NODES = 8192,
  parameter int CNT_W     = $clog2(MAX_NODES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign at_limit = (count == CNT_W'(MAX_NODES));
endmodule

// File: rtl/cmdlist_walker.sv
module cmdlist_walker
  import cw_pkg::*;
#(
  parameter int RAM_AW        = 21,
  parameter int MAX_NODES     = 8192,
  parameter int COST_W        = 32,
  parameter int NODE_COST     = 10,
  parameter int LEN_BASE_COST = 5,
  localparam int CNT_W  = $clog2(MAX_NODES + 1),
  localparam int WORD_AW = RAM_AW - 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [CW_LINK_W-1:0]  start_addr,
  output logic                  mem_req,
  output logic [RAM_AW-1:0]     mem_addr,
  input  logic                  mem_gnt,
  input  logic                  mem_rvalid,
  input  logic [CW_WORD_W-1:0]  mem_rdata,
  output logic                  out_valid,
  output logic [CW_WORD_W-1:0]  out_data,
  input  logic                  out_ready,
  output logic                  busy,
  output logic                  done,
  output logic                  err_loop,
  output logic [COST_W-1:0]     cost_total,
  output logic [CNT_W-1:0]      node_count
);
  cw_state_t              st;
  logic                   link_end;
  logic [RAM_AW-1:0]      link_addr;
  logic [WORD_AW-1:0]     rd_ptr;
  logic [CW_LEN_W-1:0]    left_q;
  logic                   walk_clr;
  logic                   hdr_take;
  logic                   at_limit;
  logic                   unused_hi_bits;

  assign unused_hi_bits = ^{start_addr[CW_END_BIT-1:RAM_AW], mem_rdata[CW_END_BIT-1:RAM_AW]};

  assign walk_clr = (st == ST_IDLE) && start;
  assign hdr_take = (st == ST_HWAIT) && mem_rvalid;

  assign mem_req  = (st == ST_HREQ) || ((st == ST_PREQ) && !out_valid);
  assign mem_addr = {rd_ptr, 2'b00};

  cw_cost_acc #(
    .COST_W(COST_W), .LEN_W(CW_LEN_W),
    .NODE_COST(NODE_COST), .LEN_BASE_COST(LEN_BASE_COST)
  ) u_cost (
    .clk(clk), .rst(rst), .clr(walk_clr), .add_en(hdr_take),
    .len(mem_rdata[CW_WORD_W-1:CW_LINK_W]), .cost(cost_total)
  );

  cw_node_guard #(.MAX_NODES(MAX_NODES), .CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst(rst), .clr(walk_clr), .inc(hdr_take),
    .count(node_count), .at_limit(at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      link_end  <= 1'b0;
      link_addr <= '0;
      rd_ptr    <= '0;
      left_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_loop  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          link_end  <= start_addr[CW_END_BIT];
          link_addr <= start_addr[RAM_AW-1:0];
          err_loop  <= 1'b0;
          busy      <= 1'b1;
          st        <= ST_NEXT;
        end
        ST_NEXT: begin
          if (link_end) begin
            st <= ST_DRAIN;
          end else if (at_limit) begin
            err_loop <= 1'b1;
            st       <= ST_DRAIN;
          end else begin
            rd_ptr <= link_addr[RAM_AW-1:2];
            st     <= ST_HREQ;
          end
        end
        ST_HREQ: if (mem_gnt) begin
          rd_ptr <= rd_ptr + 1'b1;
          st     <= ST_HWAIT;
        end
        ST_HWAIT: if (mem_rvalid) begin
          left_q    <= mem_rdata[CW_WORD_W-1:CW_LINK_W];
          link_end  <= mem_rdata[CW_END_BIT];
          link_addr <= mem_rdata[RAM_AW-1:0];
          st        <= (mem_rdata[CW_WORD_W-1:CW_LINK_W] == '0) ? ST_NEXT : ST_PREQ;
        end
        ST_PREQ: if (!out_valid && mem_gnt) begin
          rd_ptr <= rd_ptr + 1'b1;
          st     <= ST_PWAIT;
        end
        ST_PWAIT: if (mem_rvalid) begin
          out_valid <= 1'b1;
          out_data  <= mem_rdata;
          left_q    <= left_q - 1'b1;
          st        <= (left_q == CW_LEN_W'(1)) ? ST_NEXT : ST_PREQ;
        end
        ST_DRAIN: if (!out_valid) begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cw_walker_chk.sv
module cw_walker_chk #(
  parameter int RAM_AW    = 21,
  parameter int DATA_W    = 32,
  parameter int MAX_NODES = 8192,
  parameter int CNT_W     = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [RAM_AW-1:0] mem_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              busy,
  input logic              done,
  input logic              err_loop,
  input logic [CNT_W-1:0]  node_count
);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_drained_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid && !busy);

  // R6
  err_count_chk: assert property (@(posedge clk) disable iff (rst)
    err_loop |-> node_count == CNT_W'(MAX_NODES));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !out_valid);
endmodule

bind cmdlist_walker cw_walker_chk #(
  .RAM_AW(RAM_AW), .DATA_W(cw_pkg::CW_WORD_W), .MAX_NODES(MAX_NODES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy),
  .done(done), .err_loop(err_loop), .node_count(node_count)
);

// File: tb/cmdlist_walker_tb.sv
`timescale 1ns/1ps
module cmdlist_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        mem_req, mem_gnt, out_valid, busy, done, err_loop;
  logic [20:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic [31:0] cost_total;
  logic [13:0] node_count;
  logic        gnt_en = 1'b1;

  always #2 clk = ~clk;

  assign mem_gnt = mem_req & gnt_en;

  cmdlist_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done), .err_loop(err_loop),
    .cost_total(cost_total), .node_count(node_count)
  );

  typedef struct packed {
    logic [23:0] sa;
    logic [1:0]  rdy;
    logic        gnt;
    logic [13:0] nodes;
    logic [31:0] cost;
    logic        err;
    logic        chk_addr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{24'h000040, 2'd0, 1'b0, 14'd3,    32'd45,    1'b0, 1'b0},
    '{24'h000040, 2'd1, 1'b1, 14'd3,    32'd45,    1'b0, 1'b0},
    '{24'h7FFFFC, 2'd0, 1'b0, 14'd2,    32'd33,    1'b0, 1'b1},
    '{24'h800040, 2'd0, 1'b0, 14'd0,    32'd0,     1'b0, 1'b0},
    '{24'h000200, 2'd2, 1'b0, 14'd2,    32'd39,    1'b0, 1'b0},
    '{24'h000200, 2'd1, 1'b1, 14'd2,    32'd39,    1'b0, 1'b0},
    '{24'h000100, 2'd0, 1'b0, 14'd8192, 32'd81920, 1'b1, 1'b0}
  };

  logic [31:0] tbmem [256];
  int errors = 0, checks = 0, cyc = 0;
  logic [1:0] rdy_mode = 2'd0;
  logic       gnt_mode = 1'b0;
  logic       pend = 1'b0;
  logic [7:0] pend_idx = '0;
  logic [31:0] got [64];
  int          ngot = 0, ngnt = 0;
  logic [20:0] gaddr [4];
  logic        stall_prev = 1'b0;
  logic [31:0] stall_data = '0;
  int          hold_err = 0, ndone = 0;
  logic [31:0] exp_w [64];
  int          nexp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Memory responder and input pattern driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      mem_rvalid = pend;
      mem_rdata  = pend ? tbmem[pend_idx] : 32'h0;
      pend       = 1'b0;
      case (rdy_mode)
        2'd0: out_ready = 1'b1;
        2'd1: out_ready = cyc[0];
        default: out_ready = (cyc % 4) == 0;
      endcase
      gnt_en = gnt_mode ? cyc[1] : 1'b1;
    end
  end

  // Observation away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_gnt) begin
        pend     = 1'b1;
        pend_idx = mem_addr[9:2];
        if (ngnt < 4) gaddr[ngnt] = mem_addr;
        ngnt++;
      end
      if (stall_prev && !(out_valid && out_data == stall_data)) hold_err++;
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        if (ngot < 64) got[ngot] = out_data;
        ngot++;
      end
      if (done) ndone++;
    end
  end

  // Reference walk computed from the requirements
  task automatic ref_walk(input logic [23:0] sa);
    logic [23:0] a = sa;
    int n = 0;
    nexp = 0;
    while (!a[23] && n < 8192) begin
      logic [31:0] h = tbmem[a[9:2]];
      n++;
      for (int k = 1; k <= int'(h[31:24]); k++)
        if (nexp < 64) begin
          exp_w[nexp] = tbmem[8'(a[9:2] + 8'(k))];
          nexp++;
        end
      a = h[23:0];
    end
  endtask

  task automatic pulse_start(input logic [23:0] sa);
    @(posedge clk); #1;
    start = 1'b1; start_addr = sa;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t = 0;
    ok = 1'b0;
    while (t < 40000 && ndone == 0) begin
      @(negedge clk);
      t++;
    end
    ok = (ndone != 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tbmem[i] = 32'hC0DE_0000 + i * 32'h101;
    tbmem[16]  = {8'd3, 24'h000080};
    tbmem[32]  = {8'd0, 24'h0000C0};
    tbmem[48]  = {8'd2, 24'h800000};
    tbmem[255] = {8'd2, 24'h600010};
    tbmem[4]   = {8'd1, 24'hFFFFFF};
    tbmem[64]  = {8'd0, 24'h000100};
    tbmem[128] = {8'd8, 24'h000240};
    tbmem[144] = {8'd1, 24'h800000};

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!mem_req && !out_valid && !done, "R10", "handshake outputs idle", {mem_req, out_valid, done}, 0);
    check(!busy && !err_loop, "R10", "busy/err clear", {busy, err_loop}, 0);
    check(node_count == 0 && cost_total == 0, "R10", "counters clear", cost_total + node_count, 0);

    for (int v = 0; v < 7; v++) begin
      bit ok;
      int mism;
      rdy_mode = VECS[v].rdy;
      gnt_mode = VECS[v].gnt;
      ngot = 0; ngnt = 0; ndone = 0;
      ref_walk(VECS[v].sa);
      pulse_start(VECS[v].sa);
      @(negedge clk);
      check(busy == 1'b1 || VECS[v].nodes == 0, "R8", "busy after start", busy, 1);
      wait_done(ok);
      check(ok, "R8", "done seen", ok, 1);
      @(negedge clk);
      check(!done && !busy, "R8", "done one cycle, busy low", {done, busy}, 0);
      check(node_count == VECS[v].nodes, "R1", "node count", node_count, VECS[v].nodes);
      check(cost_total == VECS[v].cost, "R4", "cost total", cost_total, VECS[v].cost);
      check(err_loop == VECS[v].err, "R6", "loop error flag", err_loop, VECS[v].err);
      check(ngot == nexp, "R5", "payload word count", ngot, nexp);
      mism = 0;
      for (int i = 0; i < nexp && i < ngot; i++) if (got[i] != exp_w[i]) mism++;
      check(mism == 0, "R1", "payload order/content mismatches", mism, 0);
      check(ngnt == int'(VECS[v].nodes) + nexp, "R5", "memory reads issued", ngnt, int'(VECS[v].nodes) + nexp);
      if (VECS[v].nodes == 0)
        check(ngnt == 0, "R2", "no read on end-marked start", ngnt, 0);
      if (VECS[v].chk_addr) begin
        check(gaddr[0] == 21'h1FFFFC, "R3", "header address masked", gaddr[0], 21'h1FFFFC);
        check(gaddr[1] == 21'h000000, "R3", "payload address wraps", gaddr[1], 0);
        check(gaddr[3] == 21'h000010, "R3", "link bits 22:21 ignored", gaddr[3], 21'h10);
      end
      repeat (5) @(negedge clk);
      check(cost_total == VECS[v].cost && node_count == VECS[v].nodes, "R8", "results held", cost_total, VECS[v].cost);
    end

    // R9: start while busy ignored
    begin
      bit ok;
      rdy_mode = 2'd2; gnt_mode = 1'b0;
      ngot = 0; ngnt = 0; ndone = 0;
      pulse_start(24'h000200);
      repeat (6) @(negedge clk);
      pulse_start(24'h800040);
      wait_done(ok);
      @(negedge clk);
      check(ok && node_count == 2, "R9", "second start ignored, nodes", node_count, 2);
      check(cost_total == 39 && ngot == 9, "R9", "second start ignored, cost", cost_total, 39);
      check(ndone == 1, "R9", "single done", ndone, 1);
    end

    check(hold_err == 0, "R7", "stalled word changed", hold_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule